// File: doc/BRIEF.md
# Bit-Field XNOR Insert Unit

This execution unit carries out a single operation: it folds a bit field taken from a source operand into a destination operand. The field is not written over the destination bits. It is XNOR-combined with the destination bits already in that place. A control operand supplies a 4-bit width code and a 4-bit offset. The field holds width code + 1 bits, taken from the bottom of the source operand. The field is placed starting at the offset. Any part of the field that would fall above the most significant bit is discarded, and no error is raised. With an all-zero source the operation inverts the selected destination bits, so it can be used to toggle a field.

The instruction pipeline presents the three operands and the current carry flag with a one-cycle start strobe. One clock later, the registered result comes out together with fresh N, Z, V and C flags and a one-cycle valid pulse. The outputs hold their values between operations.

Top module: `bfx_xnor_insert`

## Requirements
- R1: The width code is `ctl_i[7:4]` and the offset is `ctl_i[3:0]`. The field covers result bits offset up to offset + width code, so width code 0 affects exactly one bit and width code 15 can cover all 16 bits.
- R2: For field position k (0 ≤ k ≤ width code), result bit offset+k equals the XNOR of `src_i[k]` and `dst_i[offset+k]`.
- R3: Every result bit outside the field equals the corresponding `dst_i` bit.
- R4: Field positions with offset + k > 15 are dropped. With offset 15, only result bit 15 can change, whatever the width code.
- R5: When `src_i` is zero, the result equals `dst_i` with every field bit inverted.
- R6: `flag_n_o` equals bit 15 of the result. `flag_z_o` is 1 exactly when the whole 16-bit result is zero.
- R7: `flag_v_o` is 0 after every operation. `flag_c_o` takes the value `c_in` had when the operation started.
- R8: The result and flags appear, and `valid_o` pulses high for exactly one cycle, on the clock edge after the edge that sampled `start_i` high. Without `start_i`, `valid_o` is low and the result and flags keep their values.
- R9: A synchronous reset (`rst_i` high at a clock edge) clears the result, all four flags and `valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Issue strobe, samples operands |
| dst_i | input | 16 | Destination operand |
| src_i | input | 16 | Source operand, field taken from bit 0 up |
| ctl_i | input | 16 | Control operand: [7:4] width code, [3:0] offset |
| c_in | input | 1 | Current carry flag, passed through |
| res_o | output | 16 | Registered result |
| valid_o | output | 1 | One-cycle result-valid pulse |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag, always cleared |
| flag_c_o | output | 1 | Carry flag, previous value kept |

## Verification
Several behaviours are checked on every cycle. Bits outside the field must be preserved. A zero source must toggle exactly the masked bits. The field mask may never cover more than width code + 1 bits. The flags must agree with the registered result. The valid pulse must follow the start strobe, and the outputs must hold while idle. Whether each field bit gets the correct source bit, and whether truncation at bit 15 lands in the right place, can only be shown by the bench. It compares every output against a bit-by-bit reference over random operands and over the edge cases: offset 15 with width code 15, width code 0, a zero source, and a reset in the middle of a run.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } bfx_flags_t;

   localparam int unsigned IMPL_OPERATOR = 0;
   localparam int unsigned IMPL_STRUCTURAL = 1;
endpackage

// File: rtl/bfx_mask_gen.sv
module bfx_mask_gen #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CODE_W = 4,
   parameter int unsigned IMPL   = 0
) (
   input  logic [CODE_W-1:0] wcode_i,
   input  logic [CODE_W-1:0] ocode_i,
   output logic [DATA_W-1:0] mask_o
);
   localparam logic [CODE_W-1:0] TOP_IDX = CODE_W'(DATA_W - 1);
   localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

   generate
      if (IMPL == bfx_pkg::IMPL_OPERATOR) begin : g_shift
         logic [DATA_W-1:0] low_ones;
         always_comb begin
            low_ones = ALL_ONES >> (TOP_IDX - wcode_i);
            mask_o   = low_ones << ocode_i;
         end
      end else begin : g_compare
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            localparam logic [CODE_W:0] IDX = (CODE_W+1)'(i);
            logic above_base;
            logic within_len;
            always_comb begin
               above_base = IDX >= {1'b0, ocode_i};
               within_len = (IDX - {1'b0, ocode_i}) <= {1'b0, wcode_i};
               mask_o[i]  = above_base && within_len;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/bfx_align.sv
module bfx_align #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CODE_W = 4,
   parameter int unsigned IMPL   = 0
) (
   input  logic [DATA_W-1:0] src_i,
   input  logic [CODE_W-1:0] ocode_i,
   output logic [DATA_W-1:0] aligned_o
);
   generate
      if (IMPL == bfx_pkg::IMPL_OPERATOR) begin : g_shift
         assign aligned_o = src_i << ocode_i;
      end else begin : g_barrel
         logic [DATA_W-1:0] stage [CODE_W+1];
         assign stage[0] = src_i;
         for (genvar k = 0; k < CODE_W; k++) begin : g_stage
            localparam int unsigned STEP = 1 << k;
            assign stage[k+1] = ocode_i[k] ? (stage[k] << STEP) : stage[k];
         end
         assign aligned_o = stage[CODE_W];
      end
   endgenerate
endmodule

// File: rtl/bfx_merge.sv
module bfx_merge #(
   parameter int unsigned DATA_W = 16
) (
   input  logic [DATA_W-1:0]  dst_i,
   input  logic [DATA_W-1:0]  aligned_i,
   input  logic [DATA_W-1:0]  mask_i,
   input  logic               c_i,
   output logic [DATA_W-1:0]  res_o,
   output bfx_pkg::bfx_flags_t flags_o
);
   logic [DATA_W-1:0] xnor_bits;
   logic [DATA_W-1:0] kept_bits;

   always_comb begin
      xnor_bits = ~(aligned_i ^ dst_i) & mask_i;
      kept_bits = dst_i & ~mask_i;
      res_o     = xnor_bits | kept_bits;
      flags_o.n = res_o[DATA_W-1];
      flags_o.z = ~|res_o;
      flags_o.v = 1'b0;
      flags_o.c = c_i;
   end
endmodule

// File: rtl/bfx_xnor_insert.sv
module bfx_xnor_insert #(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned CTL_W     = 16,
   parameter int unsigned MASK_IMPL = 0,
   parameter int unsigned SHIFT_IMPL = 0
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              start_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic [DATA_W-1:0] src_i,
   input  logic [CTL_W-1:0]  ctl_i,
   input  logic              c_in,
   output logic [DATA_W-1:0] res_o,
   output logic              valid_o,
   output logic              flag_n_o,
   output logic              flag_z_o,
   output logic              flag_v_o,
   output logic              flag_c_o
);
   import bfx_pkg::*;

   localparam int unsigned CODE_W = $clog2(DATA_W);
   localparam int unsigned OFS_LSB = 0;
   localparam int unsigned WID_LSB = CODE_W;

   generate
      if ((1 << CODE_W) != DATA_W || DATA_W < 2) begin : g_bad_width
         $error("bfx_xnor_insert: DATA_W must be a power of two, at least 2");
      end
      if (CTL_W < 2 * CODE_W) begin : g_bad_ctl
         $error("bfx_xnor_insert: CTL_W too narrow for width and offset codes");
      end
      if (MASK_IMPL > 1 || SHIFT_IMPL > 1) begin : g_bad_impl
         $error("bfx_xnor_insert: implementation selector out of range");
      end
   endgenerate

   logic [CODE_W-1:0] wcode;
   logic [CODE_W-1:0] ocode;
   assign wcode = ctl_i[WID_LSB +: CODE_W];
   assign ocode = ctl_i[OFS_LSB +: CODE_W];

   logic [DATA_W-1:0] mask_w;
   logic [DATA_W-1:0] aligned_w;
   logic [DATA_W-1:0] res_w;
   bfx_flags_t        flags_w;

   bfx_mask_gen #(.DATA_W(DATA_W), .CODE_W(CODE_W), .IMPL(MASK_IMPL)) u_mask (
      .wcode_i (wcode),
      .ocode_i (ocode),
      .mask_o  (mask_w)
   );

   bfx_align #(.DATA_W(DATA_W), .CODE_W(CODE_W), .IMPL(SHIFT_IMPL)) u_align (
      .src_i     (src_i),
      .ocode_i   (ocode),
      .aligned_o (aligned_w)
   );

   bfx_merge #(.DATA_W(DATA_W)) u_merge (
      .dst_i     (dst_i),
      .aligned_i (aligned_w),
      .mask_i    (mask_w),
      .c_i       (c_in),
      .res_o     (res_w),
      .flags_o   (flags_w)
   );

   bfx_flags_t flags_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         res_o   <= '0;
         flags_q <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= start_i;
         if (start_i) begin
            res_o   <= res_w;
            flags_q <= flags_w;
         end
      end
   end

   assign flag_n_o = flags_q.n;
   assign flag_z_o = flags_q.z;
   assign flag_v_o = flags_q.v;
   assign flag_c_o = flags_q.c;

   AST_MASK_FITS: assert property (@(posedge clk_i) disable iff (rst_i)
      start_i |-> ($countones(mask_w) <= int'(wcode) + 1)); // R4
   AST_OUTSIDE_KEPT: assert property (@(posedge clk_i) disable iff (rst_i)
      start_i |=> (((res_o ^ $past(dst_i)) & ~$past(mask_w)) == '0)); // R3
   AST_ZERO_SRC_TOGGLES: assert property (@(posedge clk_i) disable iff (rst_i)
      (start_i && src_i == '0) |=> ((res_o ^ $past(dst_i)) == $past(mask_w))); // R5
   AST_N_MATCHES: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_o |-> (flag_n_o == res_o[DATA_W-1])); // R6
   AST_Z_MATCHES: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_o |-> (flag_z_o == (res_o == '0))); // R6
   AST_V_C_UPDATE: assert property (@(posedge clk_i) disable iff (rst_i)
      start_i |=> (!flag_v_o && flag_c_o == $past(c_in))); // R7
   AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (rst_i)
      start_i |=> valid_o); // R8
   AST_NO_STRAY_VALID: assert property (@(posedge clk_i) disable iff (rst_i)
      !start_i |=> !valid_o); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      !start_i |=> ($stable(res_o) && $stable(flag_n_o) && $stable(flag_z_o)
                    && $stable(flag_c_o))); // R8
   AST_RESET_CLEARS: assert property (@(posedge clk_i)
      rst_i |=> (res_o == '0 && !valid_o && !flag_n_o && !flag_z_o
                 && !flag_v_o && !flag_c_o)); // R9
endmodule

// File: tb/tb_bfx_xnor_insert.sv
module tb_bfx_xnor_insert;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [15:0] dst = '0;
   logic [15:0] src = '0;
   logic [15:0] ctl = '0;
   logic        cin = 1'b0;
   logic [15:0] res;
   logic        valid, fn, fz, fv, fc;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [15:0] exp_res = '0;
   logic        exp_valid = 1'b0, exp_n = 1'b0, exp_z = 1'b0, exp_c = 1'b0;
   string       exp_tag = "R9";

   always #2 clk = ~clk;

   bfx_xnor_insert dut (
      .clk_i(clk), .rst_i(rst), .start_i(start), .dst_i(dst), .src_i(src),
      .ctl_i(ctl), .c_in(cin), .res_o(res), .valid_o(valid),
      .flag_n_o(fn), .flag_z_o(fz), .flag_v_o(fv), .flag_c_o(fc)
   );

   function automatic logic [15:0] model(input logic [15:0] d, input logic [15:0] s,
                                         input logic [15:0] c);
      int w = int'(c[7:4]);
      int o = int'(c[3:0]);
      logic [15:0] r = d;
      for (int k = 0; k <= w; k++) begin
         if (o + k <= 15) r[o+k] = ~(s[k] ^ d[o+k]);
      end
      return r;
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [15:0] act, input logic [15:0] expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
      end
   endtask

   task automatic compare_all();
      chk(valid === exp_valid, "R8", {exp_tag, " valid"}, 16'(valid), 16'(exp_valid));
      chk(res === exp_res, exp_tag, "result", res, exp_res);
      chk(fn === exp_n && fz === exp_z, "R6", {exp_tag, " N/Z"},
          16'({fn, fz}), 16'({exp_n, exp_z}));
      chk(fv === 1'b0 && fc === exp_c, "R7", {exp_tag, " V/C"},
          16'({fv, fc}), 16'({1'b0, exp_c}));
   endtask

   task automatic step(input logic st, input logic [15:0] d, input logic [15:0] s,
                       input logic [15:0] c, input logic ci, input string tag);
      @(negedge clk);
      compare_all();
      start = st; dst = d; src = s; ctl = c; cin = ci;
      if (st) begin
         exp_valid = 1'b1;
         exp_res   = model(d, s, c);
         exp_n     = exp_res[15];
         exp_z     = (exp_res == '0);
         exp_c     = ci;
         exp_tag   = tag;
      end else begin
         exp_valid = 1'b0;
         exp_tag   = {tag, " idle-hold"};
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      compare_all();
      rst = 1'b1; start = 1'b0;
      @(negedge clk);
      chk(res === '0 && valid === 1'b0 && {fn, fz, fv, fc} === 4'b0, "R9", "reset state",
          {res[15:4], valid, fn, fz, fc}, 16'h0);
      exp_res = '0; exp_valid = 1'b0; exp_n = 1'b0; exp_z = 1'b0; exp_c = 1'b0;
      exp_tag = "R9 post-reset";
      rst = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      chk(res === '0 && valid === 1'b0 && {fn, fz, fv, fc} === 4'b0, "R9", "initial reset",
          {res[15:4], valid, fn, fz, fc}, 16'h0);
      rst = 1'b0;
      // R1 width code 0: single bit at offset 5
      step(1, 16'hFFFF, 16'h0001, 16'h0005, 1'b1, "R1 w0 o5");
      step(1, 16'h0000, 16'h0000, 16'h0009, 1'b0, "R1 w0 o9 zero");
      // R2 full-width insert
      step(1, 16'hA5C3, 16'h3C5A, 16'h00F0, 1'b0, "R2 w15 o0");
      // R3 keep outside bits
      step(1, 16'h1234, 16'hFFFF, 16'h0034, 1'b1, "R3 w3 o4");
      // R4 truncation: offset 15 width 15
      step(1, 16'h7FFF, 16'hFFFE, 16'h00FF, 1'b0, "R4 o15 w15");
      step(1, 16'h8000, 16'h0001, 16'h00FF, 1'b1, "R4 o15 w15 b");
      step(1, 16'h00FF, 16'h0FFF, 16'h00BA, 1'b0, "R4 w11 o10");
      // R5 zero source toggles field
      step(1, 16'hF0F0, 16'h0000, 16'h0074, 1'b0, "R5 toggle w7 o4");
      step(1, 16'hFFFF, 16'h0000, 16'h00F0, 1'b1, "R5 toggle all -> zero");
      // R6 zero / negative results
      step(1, 16'h0000, 16'hFFFF, 16'h00F0, 1'b0, "R6 zero result");
      step(1, 16'h0000, 16'h0000, 16'h0000, 1'b0, "R6 toggle bit0");
      // R8 idle cycles hold values
      step(0, 16'hDEAD, 16'hBEEF, 16'h0033, 1'b1, "R8");
      step(0, 16'h0000, 16'h0000, 16'h0000, 1'b0, "R8");
      step(1, 16'hCAFE, 16'h0000, 16'h0000, 1'b1, "R8 after idle");
      // R9 mid-run reset
      do_reset();
      step(0, 16'h0, 16'h0, 16'h0, 1'b0, "R9");
      for (int n = 0; n < 400; n++) begin
         step(($urandom % 4) != 0, 16'($urandom), 16'($urandom), 16'($urandom),
              1'($urandom), "R2 random");
      end
      step(0, 16'h0, 16'h0, 16'h0, 1'b0, "R8 flush");
      step(0, 16'h0, 16'h0, 16'h0, 1'b0, "R8 flush");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule